// File: doc/BRIEF.md
# Processor Reset and Soft-Init Sequencer

This block drives the two reset lines of a host processor from the PCI clock domain. The hard reset line is held active while power is not yet good. After power-good rises it stays active for a fixed number of clock cycles and is then released on a clock edge. Software can request the same hard reset through a reset control register write. That request also raises a request that tells neighbouring register files to return to their default values.

The soft reset (INIT) line gives one fixed-length pulse. Four causes start it: a 0-to-1 change of the CPU-reset bit of the control register while its system-reset bit is clear, a fast-reset write with bit 0 set, a rising edge on the keyboard controller's reset request, and a decoded shutdown cycle. A cause that arrives while a pulse is running is dropped. A strap input picks whether both lines are active-high or active-low.

The lengths of both pulses are parameters given in clock cycles. The hard reset default is 66,000 cycles, about 2 ms at 33 MHz. The INIT default is 64 cycles.

Top module: `cpu_rst_seq`

## Requirements
- R1: While `pwr_good` is low, the hard reset is active, INIT is inactive and `regs_dflt_req` is high. After `pwr_good` rises, the hard reset is released on the HARD_CYC-th rising clock edge, so HARD_CYC-1 whole cycles are seen active.
- R2: With `pol_high`=1, `cpu_reset` and `cpu_init` are high when active. With `pol_high`=0, both are low when active.
- R3: A control register write (`rcr_wr`) with `rcr_cpu_rst`=1 and `rcr_sys_rst`=0 starts INIT only if the stored CPU-reset bit was 0. The stored bit takes the written value on every write, so writing 1 over a stored 1 does nothing.
- R4: A fast-reset write (`p92_wr`) starts INIT when `p92_fast_init`=1. With `p92_fast_init`=0 it has no effect.
- R5: A one-cycle `shutdown_cyc` pulse starts INIT.
- R6: A rising edge of `kbd_rst_req` starts INIT. Holding it high does not start INIT again.
- R7: INIT stays active for exactly INIT_CYC cycles after the edge that starts it.
- R8: A start cause that arrives while INIT is active is dropped. It neither extends the pulse nor queues a second one.
- R9: A control register write with `rcr_sys_rst`=1 and a 0-to-1 change of the CPU-reset bit activates the hard reset for exactly HARD_CYC cycles and does not start INIT. `regs_dflt_req` is high for the whole interval, and the stored CPU-reset bit is cleared, so a later write of 1 starts INIT.
- R10: A hard reset stops a running INIT pulse at once. INIT causes that arrive during a hard reset are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| pwr_good | input | 1 | Power-good; low resets the block asynchronously |
| pol_high | input | 1 | Strap: 1 = active-high outputs, 0 = active-low |
| rcr_wr | input | 1 | One-cycle write strobe of the reset control register |
| rcr_sys_rst | input | 1 | Written system-reset bit |
| rcr_cpu_rst | input | 1 | Written CPU-reset bit |
| p92_wr | input | 1 | One-cycle fast-reset port write strobe |
| p92_fast_init | input | 1 | Written bit 0 of the fast-reset port |
| kbd_rst_req | input | 1 | Keyboard controller reset request, active high level |
| shutdown_cyc | input | 1 | One-cycle pulse on a decoded shutdown cycle |
| cpu_reset | output | 1 | Processor hard reset, polarity set by `pol_high` |
| cpu_init | output | 1 | Processor soft reset, polarity set by `pol_high` |
| regs_dflt_req | output | 1 | Active-high request to return registers to their defaults |

## Verification
The hardest case to reach from the ports is a second INIT cause arriving at every possible point inside a running pulse, including its final cycle, where the counter is expiring at the same edge. The bench starts a pulse and then sweeps the offset of a second cause across the whole pulse, measuring the length each time. It does this again with INIT cut short by a register-requested hard reset, and with causes injected during that reset. The stored CPU-reset bit is checked only through its effect: after a hard reset, a write of 1 must start INIT.

// File: rtl/cpu_rst_seq_pkg.sv
`timescale 1ns/1ps
package cpu_rst_seq_pkg;

  // Map an internal active flag to the strapped pin level.
  function automatic logic pin_level(input logic active, input logic pol_high);
    return pol_high ? active : ~active;
  endfunction

  // One-cycle detect of a low-to-high change.
  function automatic logic rose(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  // Counter width that can hold a reload value of cycles-1.
  function automatic int unsigned cnt_width(input int unsigned cycles);
    return (cycles < 3) ? 1 : $clog2(cycles);
  endfunction

endpackage

// File: rtl/cpu_rst_pulse_timer.sv
`timescale 1ns/1ps
module cpu_rst_pulse_timer #(
  parameter int unsigned CYCLES          = 64,
  parameter bit          ACTIVE_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic kill,
  output logic active
);
  import cpu_rst_seq_pkg::*;

  localparam int unsigned CW = cnt_width(CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);
  localparam logic [CW-1:0] RST_CNT = ACTIVE_AT_RESET ? LOAD : '0;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= ACTIVE_AT_RESET;
      cnt    <= RST_CNT;
    end else if (kill) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      // a start while running falls through here and is dropped
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= LOAD;
    end
  end

endmodule

// File: rtl/cpu_rst_trig.sv
`timescale 1ns/1ps
module cpu_rst_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic hard_busy,
  input  logic rcr_wr,
  input  logic rcr_sys_rst,
  input  logic rcr_cpu_rst,
  input  logic p92_wr,
  input  logic p92_fast_init,
  input  logic kbd_rst_req,
  input  logic shutdown_cyc,
  output logic soft_trig,
  output logic hard_trig
);
  import cpu_rst_seq_pkg::*;

  logic cpu_bit_q;
  logic kbd_q;
  logic cpu_up;
  logic any_soft;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_bit_q <= 1'b0;
      kbd_q     <= 1'b0;
    end else begin
      kbd_q <= kbd_rst_req;
      if (hard_busy)   cpu_bit_q <= 1'b0;
      else if (rcr_wr) cpu_bit_q <= rcr_cpu_rst;
    end
  end

  assign cpu_up   = rcr_wr & rcr_cpu_rst & ~cpu_bit_q;
  assign any_soft = (cpu_up & ~rcr_sys_rst)
                  | (p92_wr & p92_fast_init)
                  | shutdown_cyc
                  | rose(kbd_rst_req, kbd_q);

  assign hard_trig = ~hard_busy & cpu_up & rcr_sys_rst;
  assign soft_trig = ~hard_busy & any_soft;

endmodule

// File: rtl/cpu_rst_seq.sv
`timescale 1ns/1ps
module cpu_rst_seq #(
  parameter int unsigned HARD_CYC = 66000,
  parameter int unsigned INIT_CYC = 64
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic pol_high,
  input  logic rcr_wr,
  input  logic rcr_sys_rst,
  input  logic rcr_cpu_rst,
  input  logic p92_wr,
  input  logic p92_fast_init,
  input  logic kbd_rst_req,
  input  logic shutdown_cyc,
  output logic cpu_reset,
  output logic cpu_init,
  output logic regs_dflt_req
);
  import cpu_rst_seq_pkg::*;

  // internal events, named for the checker
  logic hard_act;
  logic init_act;
  logic soft_trig;
  logic hard_trig;

  cpu_rst_trig u_trig (
    .clk          (clk),
    .rst_n        (pwr_good),
    .hard_busy    (hard_act),
    .rcr_wr       (rcr_wr),
    .rcr_sys_rst  (rcr_sys_rst),
    .rcr_cpu_rst  (rcr_cpu_rst),
    .p92_wr       (p92_wr),
    .p92_fast_init(p92_fast_init),
    .kbd_rst_req  (kbd_rst_req),
    .shutdown_cyc (shutdown_cyc),
    .soft_trig    (soft_trig),
    .hard_trig    (hard_trig)
  );

  cpu_rst_pulse_timer #(.CYCLES(HARD_CYC), .ACTIVE_AT_RESET(1'b1)) u_hard (
    .clk   (clk),
    .rst_n (pwr_good),
    .start (hard_trig),
    .kill  (1'b0),
    .active(hard_act)
  );

  cpu_rst_pulse_timer #(.CYCLES(INIT_CYC), .ACTIVE_AT_RESET(1'b0)) u_init (
    .clk   (clk),
    .rst_n (pwr_good),
    .start (soft_trig),
    .kill  (hard_trig),
    .active(init_act)
  );

  assign cpu_reset     = pin_level(hard_act, pol_high);
  assign cpu_init      = pin_level(init_act, pol_high);
  assign regs_dflt_req = hard_act;

endmodule

// File: rtl/cpu_rst_seq_chk.sv
`timescale 1ns/1ps
module cpu_rst_seq_chk #(
  parameter int unsigned HARD_CYC = 66000,
  parameter int unsigned INIT_CYC = 64
) (
  input logic clk,
  input logic pwr_good,
  input logic rcr_wr,
  input logic rcr_sys_rst,
  input logic hard_act,
  input logic init_act
);
  logic [31:0] hard_len;
  logic [31:0] init_len;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      hard_len <= '0;
      init_len <= '0;
    end else begin
      hard_len <= hard_act ? hard_len + 1 : '0;
      init_len <= init_act ? init_len + 1 : '0;
    end
  end

  // R1
  hard_len_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(hard_act) |-> hard_len == HARD_CYC);

  // R7
  init_full_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    ($fell(init_act) && !hard_act) |-> init_len == INIT_CYC);

  // R8
  init_no_stretch_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    init_act |-> init_len < INIT_CYC);

  // R10
  init_excl_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    !(hard_act && init_act));

  // R9
  hard_src_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(hard_act) |-> $past(rcr_wr && rcr_sys_rst));

endmodule

bind cpu_rst_seq cpu_rst_seq_chk #(.HARD_CYC(HARD_CYC), .INIT_CYC(INIT_CYC)) u_chk (
  .clk        (clk),
  .pwr_good   (pwr_good),
  .rcr_wr     (rcr_wr),
  .rcr_sys_rst(rcr_sys_rst),
  .hard_act   (hard_act),
  .init_act   (init_act)
);

// File: tb/cpu_rst_seq_bench.sv
`timescale 1ns/1ps
module cpu_rst_seq_bench;
  localparam int HC = 20;
  localparam int IC = 8;

  logic clk = 1'b0;
  logic pwr_good = 1'b0, pol_high = 1'b1;
  logic rcr_wr = 0, rcr_sys_rst = 0, rcr_cpu_rst = 0;
  logic p92_wr = 0, p92_fast_init = 0, kbd_rst_req = 0, shutdown_cyc = 0;
  logic cpu_reset, cpu_init, regs_dflt_req;

  int n_pass = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cpu_rst_seq #(.HARD_CYC(HC), .INIT_CYC(IC)) u_cpu_rst_seq (
    .clk(clk), .pwr_good(pwr_good), .pol_high(pol_high),
    .rcr_wr(rcr_wr), .rcr_sys_rst(rcr_sys_rst), .rcr_cpu_rst(rcr_cpu_rst),
    .p92_wr(p92_wr), .p92_fast_init(p92_fast_init),
    .kbd_rst_req(kbd_rst_req), .shutdown_cyc(shutdown_cyc),
    .cpu_reset(cpu_reset), .cpu_init(cpu_init), .regs_dflt_req(regs_dflt_req)
  );

  function automatic bit on(input logic pin);
    return pol_high ? (pin === 1'b1) : (pin === 1'b0);
  endfunction

  task automatic chk(input string req, input int act_v, input int exp_v);
    if (act_v == exp_v) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rcr_write(input logic sys, input logic cpu);
    rcr_wr = 1; rcr_sys_rst = sys; rcr_cpu_rst = cpu;
    step();
    rcr_wr = 0; rcr_sys_rst = 0; rcr_cpu_rst = 0;
  endtask

  // src 0: control register, 1: fast-reset port, 2: keyboard, 3: shutdown
  task automatic fire(input int src);
    case (src)
      0: begin rcr_wr = 1; rcr_cpu_rst = 1; rcr_sys_rst = 0; end
      1: begin p92_wr = 1; p92_fast_init = 1; end
      2: kbd_rst_req = 1;
      default: shutdown_cyc = 1;
    endcase
    step();
    rcr_wr = 0; rcr_cpu_rst = 0; p92_wr = 0; p92_fast_init = 0; shutdown_cyc = 0;
  endtask

  task automatic run_len(output int n);
    n = 0;
    while (on(cpu_init) && n < 1000) begin n++; step(); end
  endtask

  task automatic quiet(input int cyc, input string req);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      step();
      if (on(cpu_init)) seen++;
    end
    chk(req, seen, 0);
  endtask

  task automatic power_up();
    int n;
    step();
    pwr_good = 0;
    repeat (3) step();
    chk("R1 reset active", on(cpu_reset), 1);
    chk("R1 init idle", on(cpu_init), 0);
    chk("R1 dflt req", regs_dflt_req, 1);
    chk("R2 reset pin level", cpu_reset, pol_high);
    chk("R2 init pin level", cpu_init, !pol_high);
    pwr_good = 1;
    n = 0;
    step();
    while (on(cpu_reset) && n < 4 * HC) begin n++; step(); end
    chk("R1 release cycles", n, HC - 1);
    chk("R1 dflt req low", regs_dflt_req, 0);
  endtask

  initial begin
    int n;
    for (int p = 0; p < 2; p++) begin
      pol_high = p[0];
      power_up();

      // one pulse from each cause
      for (int src = 0; src < 4; src++) begin
        fire(src);
        run_len(n);
        case (src)
          0: chk("R3 R7 register cause", n, IC);
          1: chk("R4 R7 fast-reset cause", n, IC);
          2: chk("R6 R7 keyboard cause", n, IC);
          default: chk("R5 R7 shutdown cause", n, IC);
        endcase
        kbd_rst_req = 0;
        rcr_write(0, 0);
        quiet(3, "R7 idle after pulse");
      end

      // stored bit already 1
      rcr_write(0, 1);
      run_len(n);
      chk("R3 first write", n, IC);
      rcr_write(0, 1);
      quiet(2 * IC, "R3 repeated 1 ignored");
      rcr_write(0, 0);

      // fast-reset write with bit 0 clear
      p92_wr = 1; p92_fast_init = 0;
      step();
      p92_wr = 0;
      quiet(IC, "R4 bit0 clear ignored");

      // keyboard held high
      fire(2);
      run_len(n);
      chk("R6 edge pulse", n, IC);
      quiet(2 * IC, "R6 level held ignored");
      kbd_rst_req = 0;
      step();

      // second cause at every point of a running pulse
      for (int off = 1; off <= IC; off++) begin
        fire(1);
        n = 0;
        while (on(cpu_init) && n < 1000) begin
          n++;
          if (n == off) shutdown_cyc = 1;
          step();
          shutdown_cyc = 0;
        end
        chk($sformatf("R8 retrigger at %0d", off), n, IC);
        quiet(2, "R8 nothing queued");
      end

      // register-requested hard reset
      begin
        int dflt_bad = 0, init_bad = 0;
        rcr_write(1, 1);
        n = 0;
        while (on(cpu_reset) && n < 4 * HC) begin
          n++;
          if (!regs_dflt_req) dflt_bad++;
          if (on(cpu_init)) init_bad++;
          if (n == 2) shutdown_cyc = 1;
          if (n == 4) begin p92_wr = 1; p92_fast_init = 1; end
          step();
          shutdown_cyc = 0; p92_wr = 0; p92_fast_init = 0;
        end
        chk("R9 hard length", n, HC);
        chk("R9 dflt held", dflt_bad, 0);
        chk("R10 init off in hard", init_bad, 0);
        quiet(2, "R10 causes dropped");
        rcr_write(0, 1);
        run_len(n);
        chk("R9 stored bit cleared", n, IC);
        rcr_write(0, 0);
      end

      // hard reset cuts a running pulse
      fire(3);
      step(); step();
      chk("R10 init running", on(cpu_init), 1);
      rcr_write(1, 1);
      chk("R10 init cut", on(cpu_init), 0);
      chk("R10 hard on", on(cpu_reset), 1);
      chk("R2 reset pin in hard", cpu_reset, pol_high);
      n = 0;
      while (on(cpu_reset) && n < 4 * HC) begin n++; step(); end
      chk("R9 hard length again", n, HC);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
      $finish;
    end
  end

endmodule